// File: doc/BRIEF.md
# Data Access Address Guard

This block sits between a load/store unit and the unified translation buffer of a 32-bit core. For every data access it decides, from the top address bits and the privilege level, whether the address goes straight to the bus, needs translating, or is illegal. When translating, it asks the external translation buffer for a lookup and tells the buffer whether the process identifier must match. It then turns the buffer's answer into either a physical address or exactly one fault.

The access and the buffer's answer are presented together in one cycle, qualified by `req_valid`. One cycle later the block produces a registered response. The response holds the physical address or a one-hot fault vector, a reset-class flag for multiple hits, and the values to load into the fault-address and page-entry-high registers. The translation buffer storage itself lives outside this block.

Top module: `dxg_guard`

## Requirements
- R1: In privileged mode an address at or above 0xE0000000 is passed through unchanged with no fault.
- R2: In privileged mode an address in 0x80000000..0xBFFFFFFF is passed through with bits 31:29 cleared.
- R3: In user mode an address with bit 31 set produces an address error: fault bit 0 for a read, bit 1 for a write. The fault-address update is not requested.
- R4: In user mode, addresses 0xE0000000..0xE3FFFFFF pass through unchanged when `cfg_sq_lock` is 0. When it is 1 they fall under R3.
- R5: With `cfg_xlat_en` low, every address not covered by R1 to R4 is output with bits 31:29 cleared, and `lk_need` stays low.
- R6: With `cfg_xlat_en` high, `lk_need` is high in the request cycle for privileged 0xC0000000..0xDFFFFFFF and for user addresses below 0x80000000. `lk_asid_chk` is low only when `cfg_single_virt` and `req_priv` are both high.
- R7: A lookup with neither hit nor multi-hit raises a miss: bit 2 for a read, bit 3 for a write.
- R8: A user read of an entry whose user bit is clear raises fault bit 4. A privileged read is never a protection fault.
- R9: A privileged write needs the writable bit. A user write needs both the writable and the user bits. A failing write raises fault bit 5.
- R10: A write that passes R9 to an entry whose dirty bit is clear raises fault bit 6.
- R11: On a clean hit the physical address is (entry PPN AND mask) OR (virtual address AND NOT mask). The mask clears the low 10, 12, 16 or 20 bits for size codes 0, 1, 2, 3.
- R12: For faults 2 to 7, `rsp_tea_we` is high, `rsp_tea` equals the virtual address, and `rsp_pteh` is {address[31:10], `pteh_keep`}.
- R13: Multi-hit (fault bit 7) outranks hit and miss and raises `rsp_reset_evt`. The priority order is multi-hit, then miss, then protection, then initial write.
- R14: `rsp_valid` follows `req_valid` one cycle later. At most one fault bit is set, it is set only with `rsp_valid`, and the physical address is zero whenever a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access and lookup answer present |
| req_addr | input | 32 | Virtual data address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privileged mode |
| cfg_xlat_en | input | 1 | Address translation enabled |
| cfg_single_virt | input | 1 | Single virtual space: privileged lookups skip identifier match |
| cfg_sq_lock | input | 1 | 1 forbids user access to the store-queue window |
| pteh_keep | input | 10 | Current low bits of the page-entry-high register |
| lk_need | output | 1 | Lookup required for this access (combinational) |
| lk_asid_chk | output | 1 | Lookup must match the identifier (combinational) |
| tlb_hit | input | 1 | Single matching entry |
| tlb_multi | input | 1 | More than one matching entry |
| tlb_ppn | input | 32 | Matching entry physical page |
| tlb_size | input | 2 | Matching entry page-size code |
| tlb_user | input | 1 | Entry user-accessible bit |
| tlb_writable | input | 1 | Entry writable bit |
| tlb_dirty | input | 1 | Entry dirty bit |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 8 | One-hot fault vector |
| rsp_reset_evt | output | 1 | Reset-class event (multi-hit) |
| rsp_tea_we | output | 1 | Load fault-address and page-entry-high registers |
| rsp_tea | output | 32 | Fault address value |
| rsp_pteh | output | 32 | New page-entry-high value |

## Verification
Several checks can apply to the same access, and the block must report only the highest-ranked one. The bench sets up these overlaps on purpose. In one case a multi-hit arrives with hit also high. In another, a user write to an entry that is neither user-accessible nor dirty must report a protection fault and not an initial-write fault. The store-queue window is also tested with the lock both set and clear, so pass-through and address error compete for the same address. A behavioural model in the bench ranks the faults on its own, and every response is compared with it cycle by cycle.

// File: rtl/dxg_pkg.sv
package dxg_pkg;
  localparam int FAULT_N = 8;
  localparam int F_AERR_R = 0;
  localparam int F_AERR_W = 1;
  localparam int F_MISS_R = 2;
  localparam int F_MISS_W = 3;
  localparam int F_PROT_R = 4;
  localparam int F_PROT_W = 5;
  localparam int F_INIT_W = 6;
  localparam int F_MULTI  = 7;

  typedef enum logic [1:0] {
    RG_KEEP  = 2'd0,
    RG_STRIP = 2'd1,
    RG_AERR  = 2'd2,
    RG_XLATE = 2'd3
  } region_e;

  // number of offset bits kept from the virtual address for a size code
  function automatic int page_off_bits(input int code, input int base);
    if (code == 0) return base;
    return base + 2 + 4 * (code - 1);
  endfunction
endpackage

// File: rtl/dxg_region.sv
module dxg_region #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic              xlat_en,
  input  logic              sq_lock,
  output dxg_pkg::region_e  region
);
  import dxg_pkg::*;

  logic [2:0] top3;
  logic       sq_win;

  assign top3   = addr[ADDR_W-1 -: 3];
  assign sq_win = (addr[ADDR_W-1 -: 6] == 6'b111000);

  always_comb begin
    region = xlat_en ? RG_XLATE : RG_STRIP;
    if (priv) begin
      if (top3 == 3'b111)                         region = RG_KEEP;
      else if (top3 == 3'b100 || top3 == 3'b101)  region = RG_STRIP;
    end else if (addr[ADDR_W-1]) begin
      region = (sq_win && !sq_lock) ? RG_KEEP : RG_AERR;
    end
  end
endmodule

// File: rtl/dxg_check.sv
module dxg_check (
  input  logic                        write,
  input  logic                        priv,
  input  logic                        hit,
  input  logic                        multi,
  input  logic                        user_ok,
  input  logic                        writable,
  input  logic                        dirty,
  output logic [dxg_pkg::FAULT_N-1:0] fault
);
  import dxg_pkg::*;

  logic rd_deny;
  logic wr_deny;

  assign rd_deny = !priv && !user_ok;
  assign wr_deny = priv ? !writable : !(writable && user_ok);

  always_comb begin
    fault = '0;
    if (multi)                fault[F_MULTI]  = 1'b1;
    else if (!hit)            fault[write ? F_MISS_W : F_MISS_R] = 1'b1;
    else if (write) begin
      if (wr_deny)            fault[F_PROT_W] = 1'b1;
      else if (!dirty)        fault[F_INIT_W] = 1'b1;
    end else if (rd_deny)     fault[F_PROT_R] = 1'b1;
  end
endmodule

// File: rtl/dxg_pagemap.sv
module dxg_pagemap #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int PAGE_LSB = 10
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] ppn,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] paddr
);
  localparam int N_SIZE = 1 << SIZE_W;

  logic [ADDR_W-1:0] mask_tab [N_SIZE];
  logic [ADDR_W-1:0] mask;

  for (genvar g = 0; g < N_SIZE; g++) begin : g_mask
    localparam int OFF = dxg_pkg::page_off_bits(g, PAGE_LSB);
    assign mask_tab[g] = {{(ADDR_W-OFF){1'b1}}, {OFF{1'b0}}};
  end

  assign mask  = mask_tab[size];
  assign paddr = (ppn & mask) | (vaddr & ~mask);
endmodule

// File: rtl/dxg_guard.sv
module dxg_guard #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int PAGE_LSB = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_write,
  input  logic                        req_priv,
  input  logic                        cfg_xlat_en,
  input  logic                        cfg_single_virt,
  input  logic                        cfg_sq_lock,
  input  logic [PAGE_LSB-1:0]         pteh_keep,
  output logic                        lk_need,
  output logic                        lk_asid_chk,
  input  logic                        tlb_hit,
  input  logic                        tlb_multi,
  input  logic [ADDR_W-1:0]           tlb_ppn,
  input  logic [SIZE_W-1:0]           tlb_size,
  input  logic                        tlb_user,
  input  logic                        tlb_writable,
  input  logic                        tlb_dirty,
  output logic                        rsp_valid,
  output logic [ADDR_W-1:0]           rsp_paddr,
  output logic [dxg_pkg::FAULT_N-1:0] rsp_fault,
  output logic                        rsp_reset_evt,
  output logic                        rsp_tea_we,
  output logic [ADDR_W-1:0]           rsp_tea,
  output logic [ADDR_W-1:0]           rsp_pteh
);
  import dxg_pkg::*;

  localparam logic [ADDR_W-1:0] STRIP_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  region_e              region;
  logic [FAULT_N-1:0]   chk_fault;
  logic [ADDR_W-1:0]    mapped;

  logic [ADDR_W-1:0]    pa_d,    pa_q;
  logic [FAULT_N-1:0]   fault_d, fault_q;
  logic                 we_d,    we_q;
  logic                 valid_q;
  logic [ADDR_W-1:0]    tea_q;
  logic [ADDR_W-1:0]    pteh_q;

  dxg_region #(.ADDR_W(ADDR_W)) u_region (
    .addr    (req_addr),
    .priv    (req_priv),
    .xlat_en (cfg_xlat_en),
    .sq_lock (cfg_sq_lock),
    .region  (region)
  );

  dxg_check u_check (
    .write    (req_write),
    .priv     (req_priv),
    .hit      (tlb_hit),
    .multi    (tlb_multi),
    .user_ok  (tlb_user),
    .writable (tlb_writable),
    .dirty    (tlb_dirty),
    .fault    (chk_fault)
  );

  dxg_pagemap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PAGE_LSB(PAGE_LSB)) u_map (
    .vaddr (req_addr),
    .ppn   (tlb_ppn),
    .size  (tlb_size),
    .paddr (mapped)
  );

  assign lk_need     = req_valid && (region == RG_XLATE);
  assign lk_asid_chk = !(cfg_single_virt && req_priv);

  // next-state
  always_comb begin
    pa_d    = '0;
    fault_d = '0;
    we_d    = 1'b0;
    if (req_valid) begin
      unique case (region)
        RG_KEEP:  pa_d = req_addr;
        RG_STRIP: pa_d = req_addr & STRIP_MASK;
        RG_AERR:  fault_d[req_write ? F_AERR_W : F_AERR_R] = 1'b1;
        RG_XLATE: begin
          fault_d = chk_fault;
          we_d    = |chk_fault;
          pa_d    = (|chk_fault) ? '0 : mapped;
        end
        default:  pa_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= '0;
      we_q    <= 1'b0;
      pa_q    <= '0;
      tea_q   <= '0;
      pteh_q  <= '0;
    end else begin
      valid_q <= req_valid;
      fault_q <= fault_d;
      we_q    <= we_d;
      if (req_valid) begin
        pa_q   <= pa_d;
        tea_q  <= req_addr;
        pteh_q <= {req_addr[ADDR_W-1:PAGE_LSB], pteh_keep};
      end
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_reset_evt = fault_q[F_MULTI];
  assign rsp_tea_we    = we_q;
  assign rsp_tea       = tea_q;
  assign rsp_pteh      = pteh_q;
endmodule

// File: rtl/dxg_guard_chk.sv
module dxg_guard_chk #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        req_priv,
  input logic                        cfg_sq_lock,
  input logic [PAGE_LSB-1:0]         pteh_keep,
  input logic                        tlb_multi,
  input logic                        lk_need,
  input logic                        rsp_valid,
  input logic [ADDR_W-1:0]           rsp_paddr,
  input logic [dxg_pkg::FAULT_N-1:0] rsp_fault,
  input logic                        rsp_reset_evt,
  input logic                        rsp_tea_we,
  input logic [ADDR_W-1:0]           rsp_tea,
  input logic [ADDR_W-1:0]           rsp_pteh
);
  logic user_hi_err;
  assign user_hi_err = req_valid && !req_priv && req_addr[ADDR_W-1] &&
                       !((req_addr[ADDR_W-1 -: 6] == 6'b111000) && !cfg_sq_lock);

  a_r14_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_fault));

  a_r14_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == '0 && !rsp_tea_we));

  a_r14_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (|rsp_fault)) |-> (rsp_paddr == '0));

  a_r3_user_high: assert property (@(posedge clk) disable iff (!rst_n)
    user_hi_err |=> ((rsp_fault[0] || rsp_fault[1]) && !rsp_tea_we));

  a_r13_multi_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_need && tlb_multi) |=> (rsp_reset_evt && rsp_tea == $past(req_addr)));

  a_r12_pteh_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_tea_we || rsp_pteh[PAGE_LSB-1:0] == $past(pteh_keep)));

  a_r6_need_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    lk_need |-> req_valid);
endmodule

bind dxg_guard dxg_guard_chk #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_chk (.*);

// File: tb/sim_dxg_guard.sv
`timescale 1ns/1ps
module sim_dxg_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv;
  logic [31:0] req_addr;
  logic        cfg_xlat_en, cfg_single_virt, cfg_sq_lock;
  logic [9:0]  pteh_keep;
  logic        lk_need, lk_asid_chk;
  logic        tlb_hit, tlb_multi, tlb_user, tlb_writable, tlb_dirty;
  logic [31:0] tlb_ppn;
  logic [1:0]  tlb_size;
  logic        rsp_valid, rsp_reset_evt, rsp_tea_we;
  logic [31:0] rsp_paddr, rsp_tea, rsp_pteh;
  logic [7:0]  rsp_fault;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  dxg_guard u0 (.*);

  // pending expectation for the next negedge
  bit          e_valid;
  logic [31:0] e_pa, e_tea, e_pteh;
  logic [7:0]  e_f;
  logic        e_we;
  string       e_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model of one access
  task automatic model(input logic [31:0] a, input logic wr, pr, xen, sql,
                       input logic [9:0] keep, input logic hit, mh,
                       input logic [31:0] ppn, input logic [1:0] sz,
                       input logic u, w, d,
                       output logic [31:0] pa, output logic [7:0] f,
                       output logic we, output logic [31:0] pteh,
                       output logic need, output string tag);
    logic [31:0] m;
    pa = 0; f = 0; we = 0; need = 0; tag = "R11";
    pteh = {a[31:10], keep};
    if (pr && a >= 32'hE000_0000) begin pa = a; tag = "R1"; return; end
    if (pr && a >= 32'h8000_0000 && a < 32'hC000_0000) begin
      pa = a & 32'h1FFF_FFFF; tag = "R2"; return;
    end
    if (!pr && a >= 32'h8000_0000) begin
      if (a >= 32'hE000_0000 && a <= 32'hE3FF_FFFF) begin
        tag = "R4";
        if (!sql) begin pa = a; return; end
      end else tag = "R3";
      f = wr ? 8'h02 : 8'h01;
      return;
    end
    if (!xen) begin pa = a & 32'h1FFF_FFFF; tag = "R5"; return; end
    need = 1;
    if (mh) begin f = 8'h80; tag = "R13"; end
    else if (!hit) begin f = wr ? 8'h08 : 8'h04; tag = "R7"; end
    else if (wr && (pr ? !w : !(w && u))) begin f = 8'h20; tag = "R9"; end
    else if (wr && !d) begin f = 8'h40; tag = "R10"; end
    else if (!wr && !pr && !u) begin f = 8'h10; tag = "R8"; end
    we = (f != 0);
    if (f == 0) begin
      case (sz)
        2'd0: m = 32'hFFFF_FC00;
        2'd1: m = 32'hFFFF_F000;
        2'd2: m = 32'hFFFF_0000;
        default: m = 32'hFFF0_0000;
      endcase
      pa = (ppn & m) | (a & ~m);
      if (!wr && pr && !u) tag = "R8";
    end
  endtask

  task automatic compare_out();
    chk("R14", "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_valid});
    if (e_valid) begin
      chk(e_tag, "rsp_fault", {24'd0, rsp_fault}, {24'd0, e_f});
      chk("R13", "rsp_reset_evt", {31'd0, rsp_reset_evt}, {31'd0, e_f[7]});
      chk("R12", "rsp_tea_we", {31'd0, rsp_tea_we}, {31'd0, e_we});
      chk(e_f == 0 ? e_tag : "R14", "rsp_paddr", rsp_paddr, e_pa);
      if (e_we) begin
        chk("R12", "rsp_tea", rsp_tea, e_tea);
        chk("R12", "rsp_pteh", rsp_pteh, e_pteh);
      end
    end else begin
      chk("R14", "idle fault", {24'd0, rsp_fault}, 32'd0);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] a, input logic wr, pr,
                     xen, sv, sql, hit, mh, input logic [31:0] ppn,
                     input logic [1:0] sz, input logic u, w, d);
    logic [31:0] pa, pt;
    logic [7:0]  f;
    logic        we, need;
    string       tag;
    logic [9:0]  keep;
    @(negedge clk);
    compare_out();
    keep = 10'($urandom);
    req_valid = v; req_addr = a; req_write = wr; req_priv = pr;
    cfg_xlat_en = xen; cfg_single_virt = sv; cfg_sq_lock = sql; pteh_keep = keep;
    tlb_hit = hit; tlb_multi = mh; tlb_ppn = ppn; tlb_size = sz;
    tlb_user = u; tlb_writable = w; tlb_dirty = d;
    model(a, wr, pr, xen, sql, keep, hit, mh, ppn, sz, u, w, d, pa, f, we, pt, need, tag);
    #1;
    chk("R6", "lk_need", {31'd0, lk_need}, {31'd0, need && v});
    chk("R6", "lk_asid_chk", {31'd0, lk_asid_chk}, {31'd0, !(sv && pr)});
    e_valid = v; e_pa = pa; e_f = f; e_we = we; e_tea = a; e_pteh = pt; e_tag = tag;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; req_priv = 0;
    cfg_xlat_en = 0; cfg_single_virt = 0; cfg_sq_lock = 0; pteh_keep = 0;
    tlb_hit = 0; tlb_multi = 0; tlb_ppn = 0; tlb_size = 0;
    tlb_user = 0; tlb_writable = 0; tlb_dirty = 0;
    e_valid = 0; e_pa = 0; e_f = 0; e_we = 0; e_tea = 0; e_pteh = 0; e_tag = "R14";
    repeat (3) @(negedge clk);
    // reset state: R14
    chk("R14", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R14", "reset rsp_fault", {24'd0, rsp_fault}, 32'd0);
    rst_n = 1;
    //     v  addr           wr pr xen sv sql hit mh ppn           sz u w d
    cyc(1, 32'hFF00_1234, 0, 1, 1, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R1
    cyc(1, 32'hA123_4567, 1, 1, 1, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R2
    cyc(1, 32'h9000_0010, 0, 0, 1, 0, 0, 1, 0, 32'h0,        0, 1,1,1); // R3 read
    cyc(1, 32'hC000_0010, 1, 0, 1, 0, 0, 1, 0, 32'h0,        0, 1,1,1); // R3 write
    cyc(1, 32'hE3FF_FFE0, 1, 0, 1, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R4 open
    cyc(1, 32'hE000_0040, 0, 0, 1, 0, 1, 0, 0, 32'h0,        0, 0,0,0); // R4 locked
    cyc(1, 32'hE400_0000, 0, 0, 1, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R3 past window
    cyc(1, 32'hC812_3456, 0, 1, 0, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R5
    cyc(1, 32'h7654_3210, 1, 0, 0, 0, 0, 0, 0, 32'h0,        0, 0,0,0); // R5
    cyc(1, 32'hC000_0000, 0, 1, 1, 1, 0, 1, 0, 32'h0C00_0000,1, 0,0,0); // R6 R8 priv read ok
    cyc(1, 32'h0040_0000, 1, 0, 1, 1, 0, 0, 0, 32'h0,        0, 1,1,1); // R7 write miss
    cyc(1, 32'h0040_0000, 0, 0, 1, 0, 0, 1, 0, 32'h1,        0, 0,1,1); // R8 user read deny
    cyc(1, 32'h0040_0000, 1, 0, 1, 0, 0, 1, 0, 32'h1,        0, 0,1,0); // R9 over R10
    cyc(1, 32'hD000_0000, 1, 1, 1, 0, 0, 1, 0, 32'h1,        0, 1,0,1); // R9 priv
    cyc(1, 32'h0040_0000, 1, 0, 1, 0, 0, 1, 0, 32'h1,        0, 1,1,0); // R10
    cyc(1, 32'h1234_5678, 0, 0, 1, 0, 0, 1, 1, 32'h1,        0, 1,1,1); // R13 with hit
    for (int s = 0; s < 4; s++)                                          // R11 sizes
      cyc(1, 32'h1234_5678, 1, 0, 1, 0, 0, 1, 0, 32'hABCD_EF00, 2'(s), 1,1,1);
    cyc(0, 32'h0, 0, 0, 1, 0, 0, 0, 0, 32'h0, 0, 0,0,0);               // R14 idle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (($urandom % 4) == 0) a[31:26] = 6'b111000;
      cyc(($urandom % 8) != 0, a, 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
          1'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 10) == 0,
          $urandom, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0,0,0);
    @(negedge clk);
    compare_out();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule